// File: doc/BRIEF.md
# Banked Bus Decoder and Control Latches

This block is the glue between an 8-bit processor with a 16-bit address space and the rest of a small raster system. Each access, marked by a one-cycle read or write strobe, is sorted into a region. Memories get a chip select, and reads get their data. The processor's own memories, the video RAM, work RAM, program ROM and a banked graphics ROM, sit outside the block. The block sees them only through their selects, write enables and read-data buses. They share the processor's address and write-data lines.

A 4 KB window at 0x9000–0x9FFF shows one of sixteen graphics ROM pages, picked by a write-only page register. Only the first nine pages are populated, and reads through the window of any higher page give zero. The block also holds the write-only control state: frame interrupt enable, flip bits, scroll, sound command and page. It emits one-cycle strobes for the coin counters, the sound processor interrupt and the watchdog kick. The watchdog kick fires on a read, not a write.

Read data is combinational in the access cycle. Latches and strobes are registered and appear in the cycle after the access.

Top module: `banked_bus_glue`

## Requirements
- R1: An access at 0x0000–0x7FFF raises vram_cs in the same cycle, raises vram_we as well when it is a write, and returns vram_rdata on a read.
- R2: An access at 0x8800–0x8FFF raises wram_cs in the same cycle, raises wram_we as well when it is a write, and returns wram_rdata on a read.
- R3: A read at 0xA000–0xFFFF raises prom_cs and returns prom_rdata. A write there raises no select and changes no latch.
- R4: A write at 0x8000–0x800F raises pal_we in the same cycle, with pal_idx equal to address bits 3:0. A read there returns 0xFF.
- R5: A write at 0x8300 latches data bits 3:0 as the page. A later read at 0x9000–0x9FFF raises gfx_cs and drives gfx_addr = page*0x1000 + address bits 11:0. It returns gfx_rdata.
- R6: While the page is 9–15, a window read keeps gfx_cs low and returns 0x00.
- R7: Data bit 0 written at 0x8200 is the interrupt enable. cpu_irq is high in the cycle after frame_tick only if the enable is 1. When a write to 0x8200 and frame_tick come in the same cycle, the newly written value decides.
- R8: A read at 0x8120 makes wdog_kick high for exactly the next cycle and returns 0xFF. A write there gives no kick.
- R9: Reads return the active-low input levels unchanged: 0x8160 gives dip_a_n, 0x8180 gives coin_in_n, 0x81A0 gives p1_in_n, 0x81C0 gives p2_in_n and 0x81E0 gives dip_b_n.
- R10: A write of data bit 0 = 1 at 0x8202 or at 0x8203 makes coin_pulse[0] or coin_pulse[1] high for the next cycle only. Bit 0 = 0 gives no pulse.
- R11: Data bit 0 written at 0x8206 sets hflip and at 0x8207 sets vflip. Each holds until rewritten.
- R12: A write at 0x8100 latches scroll and a write at 0x8700 latches snd_cmd, each the full byte. Any write at 0x8600 makes snd_irq high for the next cycle only.
- R13: Synchronous reset clears every latch and strobe: interrupts are off, the page is 0 and neither flip is set.
- R14: A read of any other address returns 0xFF. A write to any other address changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid in the read cycle |
| frame_tick | input | 1 | Periodic frame interrupt request |
| cpu_irq | output | 1 | Masked interrupt toward the processor |
| vram_cs | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write enable |
| vram_rdata | input | 8 | Video RAM read data |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| wram_rdata | input | 8 | Work RAM read data |
| prom_cs | output | 1 | Program ROM select |
| prom_rdata | input | 8 | Program ROM read data |
| gfx_cs | output | 1 | Graphics ROM select |
| gfx_addr | output | 16 | Graphics ROM address (page and offset) |
| gfx_rdata | input | 8 | Graphics ROM read data |
| pal_we | output | 1 | Palette register write enable |
| pal_idx | output | 4 | Palette register index |
| dip_a_n | input | 8 | First switch bank, active low |
| dip_b_n | input | 8 | Second switch bank, active low |
| coin_in_n | input | 8 | Coin and start inputs, active low |
| p1_in_n | input | 8 | Player one inputs, active low |
| p2_in_n | input | 8 | Player two inputs, active low |
| wdog_kick | output | 1 | Watchdog restart strobe |
| coin_pulse | output | 2 | Coin counter increment strobes |
| hflip | output | 1 | Horizontal flip latch |
| vflip | output | 1 | Vertical flip latch |
| scroll | output | 8 | Scroll position latch |
| snd_cmd | output | 8 | Sound command latch |
| snd_irq | output | 1 | Interrupt strobe toward the sound processor |

## Verification
Two functions can land in the same cycle: a processor write to the interrupt enable and an incoming frame_tick. The bench raises frame_tick during the write cycle in both directions, disabling an enabled interrupt and enabling a disabled one. It then judges cpu_irq one cycle later against the newly written value. A second overlap is a page write directly followed by a window read. The bench expects the new page on gfx_addr and the matching data or zero at once.

// File: rtl/glue_pkg.sv
package glue_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [4:0] {
        RG_NONE, RG_VRAM, RG_PAL, RG_SCROLL, RG_WDOG,
        RG_DIPA, RG_COIN, RG_P1, RG_P2, RG_DIPB,
        RG_IRQEN, RG_COIN0, RG_COIN1, RG_HFLIP, RG_VFLIP,
        RG_PAGE, RG_SNDIRQ, RG_SNDCMD, RG_WRAM, RG_GFX, RG_PROM
    } region_t;

    localparam logic [15:0] A_SCROLL = 16'h8100;
    localparam logic [15:0] A_WDOG   = 16'h8120;
    localparam logic [15:0] A_DIPA   = 16'h8160;
    localparam logic [15:0] A_COIN   = 16'h8180;
    localparam logic [15:0] A_P1     = 16'h81A0;
    localparam logic [15:0] A_P2     = 16'h81C0;
    localparam logic [15:0] A_DIPB   = 16'h81E0;
    localparam logic [15:0] A_IRQEN  = 16'h8200;
    localparam logic [15:0] A_COIN0  = 16'h8202;
    localparam logic [15:0] A_COIN1  = 16'h8203;
    localparam logic [15:0] A_HFLIP  = 16'h8206;
    localparam logic [15:0] A_VFLIP  = 16'h8207;
    localparam logic [15:0] A_PAGE   = 16'h8300;
    localparam logic [15:0] A_SNDIRQ = 16'h8600;
    localparam logic [15:0] A_SNDCMD = 16'h8700;

    function automatic region_t classify(input logic [15:0] a);
        region_t r;
        r = RG_NONE;
        if (!a[15])                      r = RG_VRAM;
        else if (a[15:4] == 12'h800)     r = RG_PAL;
        else if (a == A_SCROLL)          r = RG_SCROLL;
        else if (a == A_WDOG)            r = RG_WDOG;
        else if (a == A_DIPA)            r = RG_DIPA;
        else if (a == A_COIN)            r = RG_COIN;
        else if (a == A_P1)              r = RG_P1;
        else if (a == A_P2)              r = RG_P2;
        else if (a == A_DIPB)            r = RG_DIPB;
        else if (a == A_IRQEN)           r = RG_IRQEN;
        else if (a == A_COIN0)           r = RG_COIN0;
        else if (a == A_COIN1)           r = RG_COIN1;
        else if (a == A_HFLIP)           r = RG_HFLIP;
        else if (a == A_VFLIP)           r = RG_VFLIP;
        else if (a == A_PAGE)            r = RG_PAGE;
        else if (a == A_SNDIRQ)          r = RG_SNDIRQ;
        else if (a == A_SNDCMD)          r = RG_SNDCMD;
        else if (a[15:11] == 5'b10001)   r = RG_WRAM;
        else if (a[15:12] == 4'h9)       r = RG_GFX;
        else if (a >= 16'hA000)          r = RG_PROM;
        return r;
    endfunction

endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
    import glue_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    output region_t     region,
    output logic        vram_cs,
    output logic        vram_we,
    output logic        wram_cs,
    output logic        wram_we,
    output logic        prom_cs,
    output logic        pal_we
);

    logic acc;

    always_comb begin
        acc     = rd || wr;
        region  = classify(addr);
        vram_cs = acc && (region == RG_VRAM);
        vram_we = wr  && (region == RG_VRAM);
        wram_cs = acc && (region == RG_WRAM);
        wram_we = wr  && (region == RG_WRAM);
        prom_cs = rd  && (region == RG_PROM);
        pal_we  = wr  && (region == RG_PAL);
    end

    // R1 / R2: at most one memory selected per access
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vram_cs, wram_cs, prom_cs, pal_we}));

    // R3: program ROM never selected by a write
    a_r3_prom_no_write: assert property (@(posedge clk) disable iff (rst)
        wr |-> !prom_cs);

endmodule

// File: rtl/glue_ctrl_regs.sv
module glue_ctrl_regs
    import glue_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4,
    parameter int COIN_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  region_t           region,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_tick,
    output logic [PAGE_W-1:0] page,
    output logic              irq_en,
    output logic              cpu_irq,
    output logic              wdog_kick,
    output logic [COIN_N-1:0] coin_pulse,
    output logic              hflip,
    output logic              vflip,
    output logic [DATA_W-1:0] scroll,
    output logic [DATA_W-1:0] snd_cmd,
    output logic              snd_irq
);

    typedef struct packed {
        logic              irq_en;
        logic              irq;
        logic [PAGE_W-1:0] page;
        logic              hflip;
        logic              vflip;
        logic [DATA_W-1:0] scroll;
        logic [DATA_W-1:0] snd_cmd;
        logic              snd_irq;
        logic              wdog;
        logic [COIN_N-1:0] coin;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wdog    = 1'b0;
        st_d.coin    = '0;
        st_d.snd_irq = 1'b0;
        if (wr) begin
            case (region)
                RG_IRQEN:  st_d.irq_en  = wdata[0];
                RG_PAGE:   st_d.page    = wdata[PAGE_W-1:0];
                RG_HFLIP:  st_d.hflip   = wdata[0];
                RG_VFLIP:  st_d.vflip   = wdata[0];
                RG_SCROLL: st_d.scroll  = wdata;
                RG_SNDCMD: st_d.snd_cmd = wdata;
                RG_SNDIRQ: st_d.snd_irq = 1'b1;
                RG_COIN0:  st_d.coin[0] = wdata[0];
                RG_COIN1:  st_d.coin[COIN_N-1] = wdata[0];
                default: ;
            endcase
        end
        if (rd && region == RG_WDOG) st_d.wdog = 1'b1;
        // the enable value after this cycle's write governs the tick
        st_d.irq = frame_tick && st_d.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        page       = st_q.page;
        irq_en     = st_q.irq_en;
        cpu_irq    = st_q.irq;
        wdog_kick  = st_q.wdog;
        coin_pulse = st_q.coin;
        hflip      = st_q.hflip;
        vflip      = st_q.vflip;
        scroll     = st_q.scroll;
        snd_cmd    = st_q.snd_cmd;
        snd_irq    = st_q.snd_irq;
    end

    // R7: interrupt only while enabled
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> irq_en);

    // R8: watchdog read yields kick next cycle
    a_r8_wdog_follows_read: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_WDOG) |=> wdog_kick);

    // R8: kick has no other cause
    a_r8_wdog_cause: assert property (@(posedge clk) disable iff (rst)
        wdog_kick |-> $past(rd && region == RG_WDOG));

    // R10: coin pulse only after a bit-0 write at its address
    a_r10_coin_cause: assert property (@(posedge clk) disable iff (rst)
        coin_pulse[0] |-> $past(wr && region == RG_COIN0 && wdata[0]));

    // R12: sound strobe only after a write at its address
    a_r12_sndirq_cause: assert property (@(posedge clk) disable iff (rst)
        snd_irq |-> $past(wr && region == RG_SNDIRQ));

endmodule

// File: rtl/glue_read_mux.sv
module glue_read_mux
    import glue_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int OFFS_W    = 12,
    parameter int POP_PAGES = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd,
    input  region_t                  region,
    input  logic [OFFS_W-1:0]        offs,
    input  logic [PAGE_W-1:0]        page,
    input  logic [DATA_W-1:0]        vram_rdata,
    input  logic [DATA_W-1:0]        wram_rdata,
    input  logic [DATA_W-1:0]        prom_rdata,
    input  logic [DATA_W-1:0]        gfx_rdata,
    input  logic [DATA_W-1:0]        dip_a_n,
    input  logic [DATA_W-1:0]        dip_b_n,
    input  logic [DATA_W-1:0]        coin_in_n,
    input  logic [DATA_W-1:0]        p1_in_n,
    input  logic [DATA_W-1:0]        p2_in_n,
    output logic                     gfx_cs,
    output logic [PAGE_W+OFFS_W-1:0] gfx_addr,
    output logic [DATA_W-1:0]        rdata
);

    localparam logic [PAGE_W:0] POP_LIM = (PAGE_W+1)'(POP_PAGES);

    logic page_ok;

    always_comb begin
        page_ok  = {1'b0, page} < POP_LIM;
        gfx_addr = {page, offs};
        gfx_cs   = rd && (region == RG_GFX) && page_ok;
        rdata    = '1;
        case (region)
            RG_VRAM: rdata = vram_rdata;
            RG_WRAM: rdata = wram_rdata;
            RG_PROM: rdata = prom_rdata;
            RG_GFX:  rdata = page_ok ? gfx_rdata : '0;
            RG_DIPA: rdata = dip_a_n;
            RG_DIPB: rdata = dip_b_n;
            RG_COIN: rdata = coin_in_n;
            RG_P1:   rdata = p1_in_n;
            RG_P2:   rdata = p2_in_n;
            default: rdata = '1;
        endcase
    end

    // R6: an unselected window read must come back zero
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_GFX && !gfx_cs) |-> (rdata == '0));

endmodule

// File: rtl/banked_bus_glue.sv
module banked_bus_glue
    import glue_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int OFFS_W    = 12,
    parameter int POP_PAGES = 9,
    parameter int COIN_N    = 2,
    parameter int PAL_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic [DATA_W-1:0]        cpu_rdata,
    input  logic                     frame_tick,
    output logic                     cpu_irq,
    output logic                     vram_cs,
    output logic                     vram_we,
    input  logic [DATA_W-1:0]        vram_rdata,
    output logic                     wram_cs,
    output logic                     wram_we,
    input  logic [DATA_W-1:0]        wram_rdata,
    output logic                     prom_cs,
    input  logic [DATA_W-1:0]        prom_rdata,
    output logic                     gfx_cs,
    output logic [PAGE_W+OFFS_W-1:0] gfx_addr,
    input  logic [DATA_W-1:0]        gfx_rdata,
    output logic                     pal_we,
    output logic [PAL_W-1:0]         pal_idx,
    input  logic [DATA_W-1:0]        dip_a_n,
    input  logic [DATA_W-1:0]        dip_b_n,
    input  logic [DATA_W-1:0]        coin_in_n,
    input  logic [DATA_W-1:0]        p1_in_n,
    input  logic [DATA_W-1:0]        p2_in_n,
    output logic                     wdog_kick,
    output logic [COIN_N-1:0]        coin_pulse,
    output logic                     hflip,
    output logic                     vflip,
    output logic [DATA_W-1:0]        scroll,
    output logic [DATA_W-1:0]        snd_cmd,
    output logic                     snd_irq
);

    region_t           region;
    logic [PAGE_W-1:0] page;
    logic              irq_en;

    assign pal_idx = cpu_addr[PAL_W-1:0];

    glue_addr_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .addr    (cpu_addr),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .region  (region),
        .vram_cs (vram_cs),
        .vram_we (vram_we),
        .wram_cs (wram_cs),
        .wram_we (wram_we),
        .prom_cs (prom_cs),
        .pal_we  (pal_we)
    );

    glue_ctrl_regs #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W),
        .COIN_N (COIN_N)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rd         (cpu_rd),
        .wr         (cpu_wr),
        .region     (region),
        .wdata      (cpu_wdata),
        .frame_tick (frame_tick),
        .page       (page),
        .irq_en     (irq_en),
        .cpu_irq    (cpu_irq),
        .wdog_kick  (wdog_kick),
        .coin_pulse (coin_pulse),
        .hflip      (hflip),
        .vflip      (vflip),
        .scroll     (scroll),
        .snd_cmd    (snd_cmd),
        .snd_irq    (snd_irq)
    );

    glue_read_mux #(
        .DATA_W    (DATA_W),
        .PAGE_W    (PAGE_W),
        .OFFS_W    (OFFS_W),
        .POP_PAGES (POP_PAGES)
    ) u_rmux (
        .clk        (clk),
        .rst        (rst),
        .rd         (cpu_rd),
        .region     (region),
        .offs       (cpu_addr[OFFS_W-1:0]),
        .page       (page),
        .vram_rdata (vram_rdata),
        .wram_rdata (wram_rdata),
        .prom_rdata (prom_rdata),
        .gfx_rdata  (gfx_rdata),
        .dip_a_n    (dip_a_n),
        .dip_b_n    (dip_b_n),
        .coin_in_n  (coin_in_n),
        .p1_in_n    (p1_in_n),
        .p2_in_n    (p2_in_n),
        .gfx_cs     (gfx_cs),
        .gfx_addr   (gfx_addr),
        .rdata      (cpu_rdata)
    );

    // R13: latches idle straight after reset
    a_r13_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!hflip && !vflip && !cpu_irq && page == '0));

endmodule

// File: tb/banked_bus_glue_test.sv
module banked_bus_glue_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, frame_tick = 1'b0;
    logic [7:0]  cpu_rdata, vram_rdata, wram_rdata, prom_rdata, gfx_rdata;
    logic        cpu_irq, vram_cs, vram_we, wram_cs, wram_we, prom_cs, gfx_cs, pal_we;
    logic [15:0] gfx_addr;
    logic [3:0]  pal_idx;
    logic [7:0]  dip_a_n = 8'hA5, dip_b_n = 8'h3C, coin_in_n = 8'hE7, p1_in_n = 8'h96, p2_in_n = 8'h1F;
    logic        wdog_kick, hflip, vflip, snd_irq;
    logic [1:0]  coin_pulse;
    logic [7:0]  scroll, snd_cmd;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory models
    assign vram_rdata = cpu_addr[7:0] ^ 8'h5A;
    assign wram_rdata = cpu_addr[7:0] ^ 8'hC3;
    assign prom_rdata = cpu_addr[15:8] ^ cpu_addr[7:0];
    assign gfx_rdata  = {gfx_addr[15:12], gfx_addr[3:0]};

    banked_bus_glue uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .frame_tick(frame_tick), .cpu_irq(cpu_irq),
        .vram_cs(vram_cs), .vram_we(vram_we), .vram_rdata(vram_rdata),
        .wram_cs(wram_cs), .wram_we(wram_we), .wram_rdata(wram_rdata),
        .prom_cs(prom_cs), .prom_rdata(prom_rdata),
        .gfx_cs(gfx_cs), .gfx_addr(gfx_addr), .gfx_rdata(gfx_rdata),
        .pal_we(pal_we), .pal_idx(pal_idx),
        .dip_a_n(dip_a_n), .dip_b_n(dip_b_n), .coin_in_n(coin_in_n),
        .p1_in_n(p1_in_n), .p2_in_n(p2_in_n),
        .wdog_kick(wdog_kick), .coin_pulse(coin_pulse), .hflip(hflip), .vflip(vflip),
        .scroll(scroll), .snd_cmd(snd_cmd), .snd_irq(snd_irq)
    );

    // snapshots: c_* in the access cycle, r_* one cycle later
    logic [7:0]  c_rdata;
    logic [15:0] c_gaddr;
    logic        c_vcs, c_vwe, c_wcs, c_wwe, c_pcs, c_gcs, c_pal;
    logic [3:0]  c_pidx;
    logic        r_wdog, r_irq, r_snd;
    logic [1:0]  r_coin;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
        c_rdata = cpu_rdata; c_gaddr = gfx_addr; c_vcs = vram_cs; c_vwe = vram_we;
        c_wcs = wram_cs; c_wwe = wram_we; c_pcs = prom_cs; c_gcs = gfx_cs;
        c_pal = pal_we; c_pidx = pal_idx;
        @(negedge clk);
        r_wdog = wdog_kick; r_irq = cpu_irq; r_snd = snd_irq; r_coin = coin_pulse;
        cpu_rd = 1'b0; cpu_wr = 1'b0; frame_tick = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (!a[15])                    return a[7:0] ^ 8'h5A;
        if (a[15:11] == 5'b10001)      return a[7:0] ^ 8'hC3;
        if (a >= 16'hA000)             return a[15:8] ^ a[7:0];
        case (a)
            16'h8160: return dip_a_n;
            16'h8180: return coin_in_n;
            16'h81A0: return p1_in_n;
            16'h81C0: return p2_in_n;
            16'h81E0: return dip_b_n;
            default:  return 8'hFF;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk(!hflip && !vflip && scroll == 0 && snd_cmd == 0 && !wdog_kick && coin_pulse == 0 && !snd_irq,
            "R13 latches clear", {hflip, vflip, scroll, snd_cmd}, 0);
        frame_tick = 1'b1;
        bus(1'b1, 1'b0, 16'h9005, 8'h00);
        chk(!r_irq, "R13 irq disabled", r_irq, 0);
        chk(c_gaddr == 16'h0005 && c_gcs && c_rdata == 8'h05, "R13 page zero", c_gaddr, 16'h0005);

        // R1 video RAM sweep
        for (int a = 0; a < 16'h8000; a += 16'h0137) begin
            bus(1'b1, 1'b0, 16'(a), 8'h00);
            chk(c_vcs && !c_vwe && c_rdata == exp_read(16'(a)), "R1 vram read", c_rdata, exp_read(16'(a)));
            bus(1'b0, 1'b1, 16'(a), 8'h11);
            chk(c_vcs && c_vwe && !c_wcs, "R1 vram write", {c_vcs, c_vwe}, 2'b11);
        end
        // R2 work RAM sweep
        for (int a = 16'h8800; a < 16'h9000; a += 16'h0053) begin
            bus(1'b1, 1'b0, 16'(a), 8'h00);
            chk(c_wcs && !c_wwe && c_rdata == exp_read(16'(a)), "R2 wram read", c_rdata, exp_read(16'(a)));
            bus(1'b0, 1'b1, 16'(a), 8'h22);
            chk(c_wcs && c_wwe && !c_vcs, "R2 wram write", {c_wcs, c_wwe}, 2'b11);
        end
        // R3 program ROM
        for (int a = 16'hA000; a < 32'h10000; a += 16'h0291) begin
            bus(1'b1, 1'b0, 16'(a), 8'h00);
            chk(c_pcs && c_rdata == exp_read(16'(a)), "R3 prom read", c_rdata, exp_read(16'(a)));
            bus(1'b0, 1'b1, 16'(a), 8'hFF);
            chk(!c_pcs && !c_vcs && !c_wcs && !c_pal, "R3 prom write ignored", c_pcs, 0);
        end
        chk(!hflip && !vflip && scroll == 0 && snd_cmd == 0, "R3 no latch from rom write", scroll, 0);

        // R4 palette
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, 1'b1, 16'h8000 + 16'(i), 8'(i));
            chk(c_pal && c_pidx == 4'(i), "R4 palette write", c_pidx, i);
            bus(1'b1, 1'b0, 16'h8000 + 16'(i), 8'h00);
            chk(!c_pal && c_rdata == 8'hFF, "R4 palette read", c_rdata, 8'hFF);
        end

        // R5 / R6 page sweep, write followed directly by window read
        for (int p = 0; p < 16; p++) begin
            bus(1'b0, 1'b1, 16'h8300, {4'hF, 4'(p)});
            for (int o = 0; o < 16'h1000; o += 16'h0555) begin
                bus(1'b1, 1'b0, 16'h9000 + 16'(o), 8'h00);
                if (p < 9) begin
                    chk(c_gcs && c_gaddr == 16'(p * 16'h1000 + o), "R5 gfx address", c_gaddr, p * 16'h1000 + o);
                    chk(c_rdata == {4'(p), 4'(o)}, "R5 gfx data", c_rdata, {4'(p), 4'(o)});
                end else begin
                    chk(!c_gcs && c_rdata == 8'h00, "R6 empty page", {c_gcs, c_rdata}, 0);
                end
            end
        end
        bus(1'b0, 1'b1, 16'h8300, 8'h00);

        // R7 interrupt enable and same-cycle collisions
        frame_tick = 1'b1; bus(1'b0, 1'b0, 16'h0000, 8'h00);
        chk(!r_irq, "R7 masked tick", r_irq, 0);
        bus(1'b0, 1'b1, 16'h8200, 8'h01);
        frame_tick = 1'b1; bus(1'b0, 1'b0, 16'h0000, 8'h00);
        chk(r_irq, "R7 enabled tick", r_irq, 1);
        idle();
        chk(!cpu_irq, "R7 irq one cycle", cpu_irq, 0);
        frame_tick = 1'b1; bus(1'b0, 1'b1, 16'h8200, 8'h00);
        chk(!r_irq, "R7 disable in tick cycle", r_irq, 0);
        frame_tick = 1'b1; bus(1'b0, 1'b1, 16'h8200, 8'h01);
        chk(r_irq, "R7 enable in tick cycle", r_irq, 1);
        bus(1'b0, 1'b0, 16'h0000, 8'h00);
        chk(!r_irq, "R7 no tick no irq", r_irq, 0);

        // R8 watchdog
        bus(1'b1, 1'b0, 16'h8120, 8'h00);
        chk(r_wdog && c_rdata == 8'hFF, "R8 kick on read", {r_wdog, c_rdata}, 9'h1FF);
        idle();
        chk(!wdog_kick, "R8 kick one cycle", wdog_kick, 0);
        bus(1'b0, 1'b1, 16'h8120, 8'hFF);
        chk(!r_wdog, "R8 no kick on write", r_wdog, 0);

        // R9 input ports, several patterns
        for (int k = 0; k < 4; k++) begin
            dip_a_n = 8'(k * 37 + 1); dip_b_n = 8'(k * 91 + 7); coin_in_n = 8'(~k);
            p1_in_n = 8'(k << 3 | 5); p2_in_n = 8'(8'hF0 ^ k);
            bus(1'b1, 1'b0, 16'h8160, 0); chk(c_rdata == dip_a_n, "R9 dip a", c_rdata, dip_a_n);
            bus(1'b1, 1'b0, 16'h81E0, 0); chk(c_rdata == dip_b_n, "R9 dip b", c_rdata, dip_b_n);
            bus(1'b1, 1'b0, 16'h8180, 0); chk(c_rdata == coin_in_n, "R9 coin port", c_rdata, coin_in_n);
            bus(1'b1, 1'b0, 16'h81A0, 0); chk(c_rdata == p1_in_n, "R9 p1 port", c_rdata, p1_in_n);
            bus(1'b1, 1'b0, 16'h81C0, 0); chk(c_rdata == p2_in_n, "R9 p2 port", c_rdata, p2_in_n);
        end

        // R10 coin strobes
        bus(1'b0, 1'b1, 16'h8202, 8'h01);
        chk(r_coin == 2'b01, "R10 coin0 pulse", r_coin, 2'b01);
        idle(); chk(coin_pulse == 2'b00, "R10 coin0 one cycle", coin_pulse, 0);
        bus(1'b0, 1'b1, 16'h8203, 8'hFF);
        chk(r_coin == 2'b10, "R10 coin1 pulse", r_coin, 2'b10);
        bus(1'b0, 1'b1, 16'h8202, 8'hFE);
        chk(r_coin == 2'b00, "R10 bit0 clear no pulse", r_coin, 0);

        // R11 flips
        bus(1'b0, 1'b1, 16'h8206, 8'h01);
        chk(hflip && !vflip, "R11 hflip set", {hflip, vflip}, 2'b10);
        bus(1'b0, 1'b1, 16'h8207, 8'h03);
        chk(hflip && vflip, "R11 vflip set", {hflip, vflip}, 2'b11);
        bus(1'b0, 1'b1, 16'h8206, 8'hFE);
        chk(!hflip && vflip, "R11 hflip clear", {hflip, vflip}, 2'b01);

        // R12 scroll, sound command, sound strobe
        bus(1'b0, 1'b1, 16'h8100, 8'hB7);
        chk(scroll == 8'hB7, "R12 scroll", scroll, 8'hB7);
        bus(1'b0, 1'b1, 16'h8700, 8'h4D);
        chk(snd_cmd == 8'h4D && !r_snd, "R12 sound cmd", snd_cmd, 8'h4D);
        bus(1'b0, 1'b1, 16'h8600, 8'h00);
        chk(r_snd, "R12 sound strobe", r_snd, 1);
        idle(); chk(!snd_irq, "R12 strobe one cycle", snd_irq, 0);

        // R14 unmapped read sweep over the whole control area
        for (int a = 16'h8000; a < 16'h8800; a++) begin
            bus(1'b1, 1'b0, 16'(a), 8'h00);
            if (c_rdata != exp_read(16'(a)))
                chk(1'b0, "R14 read sweep", c_rdata, exp_read(16'(a)));
        end
        chk(1'b1, "R14 read sweep done", 0, 0);
        // R14 unmapped writes leave every output alone
        for (int i = 0; i < 10; i++) begin
            logic [15:0] ua;
            case (i)
                0: ua = 16'h8201; 1: ua = 16'h8204; 2: ua = 16'h8205; 3: ua = 16'h8400;
                4: ua = 16'h8101; 5: ua = 16'h8301; 6: ua = 16'h8701; 7: ua = 16'h87FF;
                8: ua = 16'h9123; default: ua = 16'h8500;
            endcase
            bus(1'b0, 1'b1, ua, 8'hFF);
            chk(!hflip && vflip && scroll == 8'hB7 && snd_cmd == 8'h4D && !r_coin[0] && !r_coin[1]
                && !r_snd && !r_wdog && !c_vcs && !c_wcs && !c_pal,
                "R14 write ignored", {scroll, snd_cmd}, 16'hB74D);
        end
        bus(1'b1, 1'b0, 16'h9002, 8'h00);
        chk(c_gcs && c_gaddr == 16'h0002, "R14 page kept", c_gaddr, 16'h0002);

        // R13 reset again clears latches
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!vflip && scroll == 0 && snd_cmd == 0, "R13 reset clears", {vflip, scroll, snd_cmd}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule